// File: doc/BRIEF.md
# Dual-Output Programmable Reference Divider

This block divides a reference clock by a programmable ratio and gives two phase-locked loops their own comparison events. A counter, clocked by the reference, builds a divided waveform. Channel A gets a one-cycle strobe on the cycle the waveform rises. Channel B gets a one-cycle strobe on the cycle it falls. One divider therefore serves both loops, and their comparison instants are spread apart in time so the two loops disturb each other less. A select input can slow channel B to half rate. It does this by dropping every second falling-edge strobe.

The ratio is a 12-bit value. Any value below 8 is treated as 8. A new ratio is taken in with a one-cycle load pulse and held as pending. It takes effect only at the next period boundary, which is the cycle the waveform falls. As a result, no period is ever cut short or stretched. All pins are plain control and status signals, with no stream traffic. The load pulse has no back-pressure: it is always accepted in the cycle it is high, and a later pulse before the boundary replaces the pending value.

Top module: `refdiv_dual`

## Requirements
- R1: While reset is asserted and in the first cycle after it, strobe_a, strobe_b and div_wave are all low, and the counter is at zero.
- R2: After reset is released, the first strobe_a appears R - floor(R/2) clock edges later, using the reset ratio (default 10, giving edge 5). The first falling edge of div_wave appears R edges after release.
- R3: strobe_a repeats every R reference cycles.
- R4: div_wave is high for floor(R/2) cycles and low for R - floor(R/2) cycles. strobe_a is high exactly on the first high cycle of div_wave, and strobe_b can only be high on its first low cycle.
- R5: Each strobe lasts exactly one cycle, and strobe_a and strobe_b are never high in the same cycle.
- R6: With half_b low, strobe_b fires on every falling edge of div_wave, which gives a period of R.
- R7: With half_b high, strobe_b fires on every second falling edge, which gives a period of 2R. The first falling edge after reset (or after half_b goes high) is emitted.
- R8: A loaded ratio below 8 (for example 0 or 3) behaves as 8.
- R9: A ratio loaded in the middle of a period changes nothing until the next falling edge of div_wave. The current period finishes with the old ratio.
- R10: ratio_in is sampled only in cycles where ratio_ld is high. Changing it at any other time has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_in | input | 12 | Requested division ratio; values below 8 are raised to 8 |
| ratio_ld | input | 1 | One-cycle pulse that captures ratio_in as the pending ratio |
| half_b | input | 1 | When high, channel B fires on every second falling edge only |
| strobe_a | output | 1 | One-cycle comparison strobe for loop A (rising edge of div_wave) |
| strobe_b | output | 1 | One-cycle comparison strobe for loop B (falling edge of div_wave) |
| div_wave | output | 1 | Divided waveform, high for floor(R/2) cycles per period |

## Verification
A corrupted counter or active ratio shows up within one period as a wrong gap between successive strobe_a pulses, or a wrong length of the high phase of div_wave. A ratio that switches at the wrong moment shows up in the first period after a load as a falling edge at the wrong distance from the last strobe_a. A stuck or inverted half-rate toggle shows up within two periods: strobe_b is missing on the first falling edge, or it appears on two falling edges in a row. The bench measures these distances in cycles at the ports for edge ratios and random ratios, with both settings of half_b.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  typedef struct packed {
    logic a;
    logic b;
  } strobe_pair_t;
endpackage

// File: rtl/refdiv_ratio_reg.sv
module refdiv_ratio_reg #(
  parameter int RW   = 12,
  parameter int RMIN = 8,
  parameter int RDEF = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] ratio_in,
  input  logic          ratio_ld,
  input  logic          boundary,
  output logic [RW-1:0] cur_ratio
);
  localparam logic [RW-1:0] MIN_V = RW'(RMIN);
  localparam logic [RW-1:0] DEF_V = RW'(RDEF);

  logic [RW-1:0] pend_q;
  logic [RW-1:0] clamped;
  logic [RW-1:0] eff_pend;

  always_comb begin
    clamped  = (ratio_in < MIN_V) ? MIN_V : ratio_in;
    eff_pend = ratio_ld ? clamped : pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= DEF_V;
      cur_ratio <= DEF_V;
    end else begin
      pend_q <= eff_pend;
      if (boundary) cur_ratio <= eff_pend;
    end
  end
endmodule

// File: rtl/refdiv_counter.sv
module refdiv_counter #(
  parameter int RW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] cur_ratio,
  output logic          boundary,
  output logic          rise_next,
  output logic          wave
);
  localparam logic [RW-1:0] ONE = RW'(1);

  logic [RW-1:0] cnt_q;
  logic [RW-1:0] cnt_nxt;
  logic [RW-1:0] low_len;

  always_comb begin
    low_len   = cur_ratio - (cur_ratio >> 1);
    boundary  = (cnt_q == cur_ratio - ONE);
    cnt_nxt   = boundary ? '0 : cnt_q + ONE;
    rise_next = (cnt_nxt == low_len);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      wave  <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      wave  <= (cnt_nxt >= low_len);
    end
  end
endmodule

// File: rtl/refdiv_strobes.sv
module refdiv_strobes
  import refdiv_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         half_b,
  input  logic         rise_next,
  input  logic         boundary,
  output strobe_pair_t stb
);
  logic skip_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb    <= '0;
      skip_q <= 1'b0;
    end else begin
      stb.a <= rise_next;
      stb.b <= boundary && !(half_b && skip_q);
      if (!half_b)       skip_q <= 1'b0;
      else if (boundary) skip_q <= !skip_q;
    end
  end
endmodule

// File: rtl/refdiv_dual.sv
module refdiv_dual
  import refdiv_pkg::*;
#(
  parameter int RW   = 12,
  parameter int RMIN = 8,
  parameter int RDEF = 10
) (
  input  logic          clk_ref,
  input  logic          rst_n,
  input  logic [RW-1:0] ratio_in,
  input  logic          ratio_ld,
  input  logic          half_b,
  output logic          strobe_a,
  output logic          strobe_b,
  output logic          div_wave
);
  logic [RW-1:0] cur_ratio;
  logic          boundary;
  logic          rise_next;
  strobe_pair_t  stb;

  refdiv_ratio_reg #(.RW(RW), .RMIN(RMIN), .RDEF(RDEF)) u_ratio (
    .clk(clk_ref), .rst_n(rst_n), .ratio_in(ratio_in), .ratio_ld(ratio_ld),
    .boundary(boundary), .cur_ratio(cur_ratio)
  );

  refdiv_counter #(.RW(RW)) u_cnt (
    .clk(clk_ref), .rst_n(rst_n), .cur_ratio(cur_ratio),
    .boundary(boundary), .rise_next(rise_next), .wave(div_wave)
  );

  refdiv_strobes u_stb (
    .clk(clk_ref), .rst_n(rst_n), .half_b(half_b), .rise_next(rise_next),
    .boundary(boundary), .stb(stb)
  );

  assign strobe_a = stb.a;
  assign strobe_b = stb.b;
endmodule

// File: rtl/refdiv_dual_chk.sv
module refdiv_dual_chk (
  input logic clk,
  input logic rst_n,
  input logic half_b,
  input logic strobe_a,
  input logic strobe_b,
  input logic div_wave
);
  // R1: outputs are cleared by reset
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (!strobe_a && !strobe_b && !div_wave));

  // R5: strobes are exclusive and one cycle wide
  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe_a && strobe_b));
  assert_a_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_a |=> !strobe_a);
  assert_b_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_b |=> !strobe_b);

  // R4: strobe_a coincides with the rising edge of div_wave, strobe_b with a falling edge
  assert_a_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_a |-> $rose(div_wave));
  assert_rise_gives_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(div_wave) |-> strobe_a);
  assert_b_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_b |-> $fell(div_wave));

  // R6: in full-rate mode every falling edge carries strobe_b
  assert_b_full_rate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(div_wave) && !$past(half_b)) |-> strobe_b);
endmodule

bind refdiv_dual refdiv_dual_chk u_chk (
  .clk(clk_ref), .rst_n(rst_n), .half_b(half_b),
  .strobe_a(strobe_a), .strobe_b(strobe_b), .div_wave(div_wave)
);

// File: tb/refdiv_dual_test.sv
module refdiv_dual_test;
  localparam int CLK_PERIOD = 10;

  logic        clk_ref = 1'b0;
  logic        rst_n;
  logic [11:0] ratio_in;
  logic        ratio_ld;
  logic        half_b;
  logic        strobe_a, strobe_b, div_wave;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  logic prev_a = 1'b0, prev_b = 1'b0;

  refdiv_dual uut (
    .clk_ref(clk_ref), .rst_n(rst_n), .ratio_in(ratio_in), .ratio_ld(ratio_ld),
    .half_b(half_b), .strobe_a(strobe_a), .strobe_b(strobe_b), .div_wave(div_wave)
  );

  always #(CLK_PERIOD/2) clk_ref = ~clk_ref;

  always @(posedge clk_ref) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  function automatic int eff_ratio(int r);
    return (r < 8) ? 8 : r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R5 monitor: exclusivity and one-cycle width, checked on each strobe
  always @(negedge clk_ref) begin
    if (rst_n === 1'b1 && (strobe_a || strobe_b)) begin
      chk(!(strobe_a && strobe_b), "R5 overlap", int'(strobe_b), 0);
      if (strobe_a) chk(!prev_a, "R5 width a", int'(prev_a), 0);
      if (strobe_b) chk(!prev_b, "R5 width b", int'(prev_b), 0);
    end
    prev_a = strobe_a;
    prev_b = strobe_b;
  end

  task automatic wait_a(output int t);
    do @(negedge clk_ref); while (!strobe_a);
    t = cyc;
  endtask

  task automatic wait_fall(output int t, output bit bflag);
    logic p;
    p = div_wave;
    forever begin
      @(negedge clk_ref);
      if (p && !div_wave) break;
      p = div_wave;
    end
    t = cyc;
    bflag = strobe_b;
  endtask

  task automatic load(input int r);
    @(negedge clk_ref);
    ratio_in = 12'(r);
    ratio_ld = 1'b1;
    @(negedge clk_ref);
    ratio_ld = 1'b0;
  endtask

  task automatic run_case(input int r, input bit sr);
    int e, t1, t2, tf, nb;
    bit bf;
    e = eff_ratio(r);
    half_b = sr;
    load(r);
    wait_fall(tf, bf);
    wait_a(t1);
    wait_fall(tf, bf);
    wait_a(t2);
    chk(t2 - t1 == e, "R3 period", t2 - t1, e);
    chk(tf - t1 == e / 2, "R4 high length", tf - t1, e / 2);
    chk(t2 - tf == e - e / 2, "R4 low length", t2 - tf, e - e / 2);
    if (r < 8) chk(t2 - t1 == 8, "R8 clamp", t2 - t1, 8);
    nb = 0;
    for (int k = 0; k < 4; k++) begin
      wait_fall(tf, bf);
      nb += int'(bf);
    end
    if (sr) chk(nb == 2, "R7 half rate count", nb, 2);
    else    chk(nb == 4, "R6 full rate count", nb, 4);
  endtask

  initial begin
    int t, t1, t2;
    bit bf;
    rst_n = 1'b0; ratio_in = '0; ratio_ld = 1'b0; half_b = 1'b1;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_ref);
    chk(!strobe_a && !strobe_b && !div_wave, "R1 reset outputs",
        int'({strobe_a, strobe_b, div_wave}), 0);
    rst_n = 1'b1;
    @(negedge clk_ref);
    chk(!strobe_a && !strobe_b && !div_wave, "R1 first cycle",
        int'({strobe_a, strobe_b, div_wave}), 0);
    wait_a(t);
    chk(t == 5, "R2 first strobe_a", t, 5);
    wait_fall(t, bf);
    chk(t == 10, "R2 first fall", t, 10);
    chk(bf, "R7 first strobe_b emitted", int'(bf), 1);
    wait_fall(t, bf);
    chk(!bf, "R7 second strobe_b skipped", int'(bf), 0);

    run_case(8, 1'b0);
    run_case(8, 1'b1);
    run_case(13, 1'b0);
    run_case(13, 1'b1);
    run_case(3, 1'b0);
    run_case(0, 1'b1);
    run_case(4095, 1'b0);

    // R9: mid-period load keeps the current period
    run_case(20, 1'b0);
    wait_a(t1);
    load(30);
    wait_fall(t2, bf);
    chk(t2 - t1 == 10, "R9 old high phase kept", t2 - t1, 10);
    wait_a(t);
    chk(t - t2 == 15, "R9 new low phase", t - t2, 15);

    // R10: ratio_in changes without ratio_ld are ignored
    ratio_in = 12'd50;
    wait_a(t1);
    ratio_in = 12'd9;
    wait_a(t2);
    chk(t2 - t1 == 30, "R10 ratio_in ignored", t2 - t1, 30);

    for (int i = 0; i < 6; i++) begin
      run_case(int'($urandom_range(8, 600)), bit'($urandom_range(0, 1)));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule